// File: doc/BRIEF.md
# Load/Store Byte-Lane Unit

This unit sits between a 32-bit integer datapath and a data memory that is one word wide. It forms the effective address from the base register and the 12-bit signed offset carried by the instruction. It then moves that address down from the fixed base at which data memory is mapped, so that it becomes a local byte address. Finally it works out which byte lanes of the memory word an access touches.

On a load, the unit takes the word read from memory and picks out the byte, halfword or word that the access asks for. It returns that value widened to 32 bits, with a sign extension or a zero extension chosen by the access code. On a store, it produces a word-aligned local address, write data with the source bytes copied into every lane, and one write enable per byte. The whole unit is combinational, so all outputs follow the inputs within the same cycle. Memory is little-endian.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is the base value plus the sign-extended 12-bit offset. The offset's upper 7 bits come from `imm_upper` in both cases. Its lower 5 bits come from `imm_lo_i` when `st_sel`=0 (load) and from `imm_lo_s` when `st_sel`=1 (store).
- R2: `mem_addr` equals the effective address minus 0x80000000, with bits [1:0] forced to zero. Subtraction wraps modulo 2^32.
- R3: A load with access code 0 returns the byte in lane (local address bits [1:0]), sign-extended. Lane k holds `rd_word` bits [8k+7:8k].
- R4: A load with access code 1 returns the halfword selected by local address bit 1 (0 picks bits [15:0], 1 picks bits [31:16]), sign-extended. Address bit 0 is ignored.
- R5: A load with access code 2 returns `rd_word` unchanged.
- R6: Access code 4 returns the byte of R3, and access code 5 returns the halfword of R4, both zero-extended.
- R7: `ld_result` is zero when `st_sel`=1, and also for load access codes 3, 6 and 7.
- R8: A store with access code 0 sets `wr_be` to 4'b0001 shifted left by address bits [1:0], and sets `wr_data` to four copies of `store_src[7:0]`.
- R9: A store with access code 1 sets `wr_be` to 4'b0011 when address bit 1 is 0 and to 4'b1100 when it is 1. `wr_data` is two copies of `store_src[15:0]`.
- R10: A store with access code 2 sets `wr_be` to 4'b1111, and `wr_data` equals `store_src`.
- R11: `wr_be` is 4'b0000 for store access codes 3 to 7, and whenever `st_sel`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| st_sel | input | 1 | 1 = store access, 0 = load access |
| funct3 | input | 3 | Access width/extension code |
| imm_upper | input | 7 | Offset bits [11:5] |
| imm_lo_i | input | 5 | Offset bits [4:0] for loads |
| imm_lo_s | input | 5 | Offset bits [4:0] for stores |
| base_val | input | 32 | Base register value |
| store_src | input | 32 | Value to be stored |
| rd_word | input | 32 | Word read from data memory |
| mem_addr | output | 32 | Word-aligned local memory address |
| wr_data | output | 32 | Lane-replicated store data |
| wr_be | output | 4 | Per-byte write enables |
| ld_result | output | 32 | Extended load value |

## Verification
Some rules are checked continuously against any input: the shape of the enable pattern for each store code, the absence of enables on loads and on unknown codes, the lane contents under enabled bytes, and the form of the upper result bits for signed and unsigned narrow loads. Other properties can only be shown by the bench's scenarios, because they depend on specific values. These include the exact relocated address, the choice of offset field, the wrap of addresses below the memory base, and which lane a given offset selects, including negative and extreme offsets.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN = 32;
    localparam logic [XLEN-1:0] DMEM_BASE = 32'h8000_0000;

    localparam logic [2:0] F3_BYTE  = 3'd0;
    localparam logic [2:0] F3_HALF  = 3'd1;
    localparam logic [2:0] F3_WORD  = 3'd2;
    localparam logic [2:0] F3_UBYTE = 3'd4;
    localparam logic [2:0] F3_UHALF = 3'd5;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_HALF = 2'd2,
        SZ_WORD = 2'd3
    } acc_size_e;

    typedef struct packed {
        acc_size_e size;
        logic      sext;
    } acc_ctl_t;

    localparam acc_ctl_t CTL_IDLE = '{size: SZ_NONE, sext: 1'b0};

    function automatic acc_ctl_t decode_load(input logic [2:0] code);
        acc_ctl_t c;
        c = CTL_IDLE;
        unique case (code)
            F3_BYTE:  c = '{size: SZ_BYTE, sext: 1'b1};
            F3_HALF:  c = '{size: SZ_HALF, sext: 1'b1};
            F3_WORD:  c = '{size: SZ_WORD, sext: 1'b0};
            F3_UBYTE: c = '{size: SZ_BYTE, sext: 1'b0};
            F3_UHALF: c = '{size: SZ_HALF, sext: 1'b0};
            default:  c = CTL_IDLE;
        endcase
        return c;
    endfunction

    function automatic acc_ctl_t decode_store(input logic [2:0] code);
        acc_ctl_t c;
        c = CTL_IDLE;
        unique case (code)
            F3_BYTE: c = '{size: SZ_BYTE, sext: 1'b0};
            F3_HALF: c = '{size: SZ_HALF, sext: 1'b0};
            F3_WORD: c = '{size: SZ_WORD, sext: 1'b0};
            default: c = CTL_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lsu_ea_reloc.sv
module lsu_ea_reloc #(
    parameter int             AW   = lsu_pkg::XLEN,
    parameter int             IW   = 12,
    parameter logic [AW-1:0]  BASE = lsu_pkg::DMEM_BASE
) (
    input  logic [AW-1:0] base_val,
    input  logic [IW-1:0] offset,
    output logic [AW-1:0] local_addr
);
    logic [AW-1:0] offset_ext;
    logic [AW-1:0] eff_addr;

    assign offset_ext = {{(AW-IW){offset[IW-1]}}, offset};
    assign eff_addr   = base_val + offset_ext;
    assign local_addr = eff_addr - BASE;
endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane
    import lsu_pkg::*;
#(
    parameter int DW = lsu_pkg::XLEN,
    localparam int NB = DW / 8,
    localparam int OW = $clog2(NB)
) (
    input  acc_ctl_t        ctl,
    input  logic [OW-1:0]   lane_off,
    input  logic [DW-1:0]   rd_word,
    output logic [DW-1:0]   result
);
    logic [7:0]  pick_b;
    logic [15:0] pick_h;
    logic [OW-2:0] half_idx;

    assign half_idx = lane_off[OW-1:1];
    assign pick_b   = rd_word[8*int'(lane_off) +: 8];
    assign pick_h   = rd_word[16*int'(half_idx) +: 16];

    always_comb begin
        unique case (ctl.size)
            SZ_BYTE: result = {{(DW-8){ctl.sext & pick_b[7]}}, pick_b};
            SZ_HALF: result = {{(DW-16){ctl.sext & pick_h[15]}}, pick_h};
            SZ_WORD: result = rd_word;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_pkg::*;
#(
    parameter int DW = lsu_pkg::XLEN,
    localparam int NB = DW / 8,
    localparam int OW = $clog2(NB)
) (
    input  acc_ctl_t        ctl,
    input  logic [OW-1:0]   lane_off,
    input  logic [DW-1:0]   src,
    output logic [DW-1:0]   wr_data,
    output logic [NB-1:0]   wr_be
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic       lane_en;
        logic [7:0] lane_byte;

        always_comb begin
            unique case (ctl.size)
                SZ_BYTE: begin
                    lane_en   = (lane_off == OW'(i));
                    lane_byte = src[7:0];
                end
                SZ_HALF: begin
                    lane_en   = (lane_off[OW-1:1] == (OW-1)'(i / 2));
                    lane_byte = src[8*(i%2) +: 8];
                end
                SZ_WORD: begin
                    lane_en   = 1'b1;
                    lane_byte = src[8*i +: 8];
                end
                default: begin
                    lane_en   = 1'b0;
                    lane_byte = 8'h00;
                end
            endcase
        end

        assign wr_be[i]          = lane_en;
        assign wr_data[8*i +: 8] = lane_byte;
    end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int            DW       = lsu_pkg::XLEN,
    parameter logic [DW-1:0] MEM_BASE = lsu_pkg::DMEM_BASE,
    localparam int NB = DW / 8,
    localparam int OW = $clog2(NB)
) (
    input  logic          st_sel,
    input  logic [2:0]    funct3,
    input  logic [6:0]    imm_upper,
    input  logic [4:0]    imm_lo_i,
    input  logic [4:0]    imm_lo_s,
    input  logic [DW-1:0] base_val,
    input  logic [DW-1:0] store_src,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] wr_data,
    output logic [NB-1:0] wr_be,
    output logic [DW-1:0] ld_result
);
    logic [11:0]   offset;
    logic [DW-1:0] loc_addr;
    acc_ctl_t      ld_ctl;
    acc_ctl_t      st_ctl;

    assign offset = st_sel ? {imm_upper, imm_lo_s} : {imm_upper, imm_lo_i};
    assign ld_ctl = st_sel ? CTL_IDLE : decode_load(funct3);
    assign st_ctl = st_sel ? decode_store(funct3) : CTL_IDLE;

    lsu_ea_reloc #(.AW(DW), .IW(12), .BASE(MEM_BASE)) u_reloc (
        .base_val   (base_val),
        .offset     (offset),
        .local_addr (loc_addr)
    );

    lsu_load_lane #(.DW(DW)) u_load (
        .ctl      (ld_ctl),
        .lane_off (loc_addr[OW-1:0]),
        .rd_word  (rd_word),
        .result   (ld_result)
    );

    lsu_store_lane #(.DW(DW)) u_store (
        .ctl      (st_ctl),
        .lane_off (loc_addr[OW-1:0]),
        .src      (store_src),
        .wr_data  (wr_data),
        .wr_be    (wr_be)
    );

    assign mem_addr = {loc_addr[DW-1:OW], {OW{1'b0}}};
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk #(
    parameter int DW = 32,
    localparam int NB = DW / 8
) (
    input logic          st_sel,
    input logic [2:0]    funct3,
    input logic [DW-1:0] store_src,
    input logic [DW-1:0] wr_data,
    input logic [NB-1:0] wr_be,
    input logic [DW-1:0] ld_result
);
    logic known;
    assign known = !$isunknown({st_sel, funct3, store_src, wr_data, wr_be, ld_result});

    always_comb begin
        if (known) begin
            if (!st_sel)
                AST_LOAD_NO_WRITE: assert (wr_be == '0) else $error("load drove enables"); // R11
            if (st_sel && funct3 > 3'd2)
                AST_BAD_STORE_CODE: assert (wr_be == '0) else $error("unknown store code wrote"); // R11
            if (st_sel && funct3 == 3'd0)
                AST_SB_ONE_LANE: assert ($countones(wr_be) == 1) else $error("byte store lane count"); // R8
            if (st_sel && funct3 == 3'd1)
                AST_SH_LANE_PAIR: assert (wr_be == 4'b0011 || wr_be == 4'b1100) else $error("half store lanes"); // R9
            if (st_sel && funct3 == 3'd2)
                AST_SW_ALL_LANES: assert (&wr_be) else $error("word store lanes"); // R10
            if (st_sel)
                AST_STORE_NO_LOAD: assert (ld_result == '0) else $error("store returned load data"); // R7
            if (!st_sel && (funct3 == 3'd3 || funct3 > 3'd5))
                AST_BAD_LOAD_ZERO: assert (ld_result == '0) else $error("unknown load code nonzero"); // R7
            if (!st_sel && funct3 == 3'd0)
                AST_LB_SIGN_FILL: assert (ld_result[DW-1:8] == {(DW-8){ld_result[7]}}) else $error("byte sign fill"); // R3
            if (!st_sel && funct3 == 3'd1)
                AST_LH_SIGN_FILL: assert (ld_result[DW-1:16] == {(DW-16){ld_result[15]}}) else $error("half sign fill"); // R4
            if (!st_sel && funct3 == 3'd4)
                AST_LBU_ZERO_FILL: assert (ld_result[DW-1:8] == '0) else $error("byte zero fill"); // R6
            if (!st_sel && funct3 == 3'd5)
                AST_LHU_ZERO_FILL: assert (ld_result[DW-1:16] == '0) else $error("half zero fill"); // R6
            for (int i = 0; i < NB; i++) begin
                if (st_sel && funct3 == 3'd0 && wr_be[i])
                    AST_SB_LANE_DATA: assert (wr_data[8*i +: 8] == store_src[7:0]) else $error("byte lane data"); // R8
            end
        end
    end
endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.DW(DW)) u_chk (
    .st_sel    (st_sel),
    .funct3    (funct3),
    .store_src (store_src),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .ld_result (ld_result)
);

// File: tb/lsu_lane_unit_tb.sv
module lsu_lane_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_sel;
    logic [2:0]  funct3;
    logic [6:0]  imm_upper;
    logic [4:0]  imm_lo_i;
    logic [4:0]  imm_lo_s;
    logic [31:0] base_val;
    logic [31:0] store_src;
    logic [31:0] rd_word;
    logic [31:0] mem_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic [31:0] ld_result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lsu_lane_unit u_dut (
        .st_sel    (st_sel),
        .funct3    (funct3),
        .imm_upper (imm_upper),
        .imm_lo_i  (imm_lo_i),
        .imm_lo_s  (imm_lo_s),
        .base_val  (base_val),
        .store_src (store_src),
        .rd_word   (rd_word),
        .mem_addr  (mem_addr),
        .wr_data   (wr_data),
        .wr_be     (wr_be),
        .ld_result (ld_result)
    );

    typedef struct packed {
        logic        st;
        logic [2:0]  f3;
        logic [11:0] imm;
        logic [31:0] base;
        logic [31:0] src;
        logic [31:0] rw;
        logic [31:0] e_addr;
        logic [31:0] e_res;
        logic [3:0]  e_be;
        logic [31:0] e_data;
        logic [7:0]  req;
    } vec_t;

    localparam logic [31:0] RW = 32'h8A7B_C6F5;
    localparam logic [31:0] SV = 32'h1234_56A9;

    localparam vec_t VECS [18] = '{
        '{1'b0, 3'd0, 12'h000, 32'h8000_0100, SV, RW, 32'h100, 32'hFFFF_FFF5, 4'h0, 32'h0, 8'd3},  // R3 lane 0
        '{1'b0, 3'd0, 12'h001, 32'h8000_0100, SV, RW, 32'h100, 32'hFFFF_FFC6, 4'h0, 32'h0, 8'd3},  // R3 lane 1
        '{1'b0, 3'd0, 12'h002, 32'h8000_0100, SV, RW, 32'h100, 32'h0000_007B, 4'h0, 32'h0, 8'd3},  // R3 positive byte
        '{1'b0, 3'd0, 12'h003, 32'h8000_0100, SV, RW, 32'h100, 32'hFFFF_FF8A, 4'h0, 32'h0, 8'd3},  // R3 lane 3
        '{1'b0, 3'd4, 12'h000, 32'h8000_0100, SV, RW, 32'h100, 32'h0000_00F5, 4'h0, 32'h0, 8'd6},  // R6 unsigned byte
        '{1'b0, 3'd1, 12'h000, 32'h8000_0100, SV, RW, 32'h100, 32'hFFFF_C6F5, 4'h0, 32'h0, 8'd4},  // R4 low half
        '{1'b0, 3'd1, 12'h002, 32'h8000_0100, SV, RW, 32'h100, 32'hFFFF_8A7B, 4'h0, 32'h0, 8'd4},  // R4 high half
        '{1'b0, 3'd1, 12'h003, 32'h8000_0100, SV, RW, 32'h100, 32'hFFFF_8A7B, 4'h0, 32'h0, 8'd4},  // R4 bit 0 ignored
        '{1'b0, 3'd5, 12'h002, 32'h8000_0100, SV, RW, 32'h100, 32'h0000_8A7B, 4'h0, 32'h0, 8'd6},  // R6 unsigned half
        '{1'b0, 3'd2, 12'hFF0, 32'h8000_0210, SV, RW, 32'h200, 32'h8A7B_C6F5, 4'h0, 32'h0, 8'd5},  // R5 negative offset
        '{1'b0, 3'd3, 12'h000, 32'h8000_0100, SV, RW, 32'h100, 32'h0000_0000, 4'h0, 32'h0, 8'd7},  // R7 code 3
        '{1'b0, 3'd7, 12'h000, 32'h8000_0100, SV, RW, 32'h100, 32'h0000_0000, 4'h0, 32'h0, 8'd7},  // R7 code 7
        '{1'b1, 3'd0, 12'h001, 32'h8000_0040, SV, RW, 32'h040, 32'h0, 4'b0010, 32'hA9A9_A9A9, 8'd8}, // R8 lane 1
        '{1'b1, 3'd0, 12'h7FF, 32'h8000_0040, SV, RW, 32'h83C, 32'h0, 4'b1000, 32'hA9A9_A9A9, 8'd8}, // R8 max offset
        '{1'b1, 3'd1, 12'h000, 32'h8000_0040, SV, RW, 32'h040, 32'h0, 4'b0011, 32'h56A9_56A9, 8'd9}, // R9 low half
        '{1'b1, 3'd1, 12'h002, 32'h8000_0040, SV, RW, 32'h040, 32'h0, 4'b1100, 32'h56A9_56A9, 8'd9}, // R9 high half
        '{1'b1, 3'd2, 12'h800, 32'h8000_1000, SV, RW, 32'h800, 32'h0, 4'b1111, SV, 8'd10},           // R10 min offset
        '{1'b1, 3'd5, 12'h000, 32'h8000_0040, SV, RW, 32'h040, 32'h0, 4'b0000, 32'h0, 8'd11}          // R11 code 5
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", what, act, exp);
        end
    endtask

    task automatic drive(input logic st, input logic [2:0] f3, input logic [6:0] up,
                         input logic [4:0] lo_i, input logic [4:0] lo_s,
                         input logic [31:0] base, input logic [31:0] src, input logic [31:0] rw);
        @(negedge clk);
        st_sel    = st;
        funct3    = f3;
        imm_upper = up;
        imm_lo_i  = lo_i;
        imm_lo_s  = lo_s;
        base_val  = base;
        store_src = src;
        rd_word   = rw;
        @(posedge clk);
        #5;
    endtask

    initial begin
        st_sel = 1'b0; funct3 = 3'd0; imm_upper = '0; imm_lo_i = '0; imm_lo_s = '0;
        base_val = '0; store_src = '0; rd_word = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #5;
        // reset state: zero inputs, base below memory window wraps (R2)
        check("R2 reset mem_addr", mem_addr, 32'h8000_0000);
        check("R7 reset ld_result", ld_result, 32'h0);
        check("R11 reset wr_be", {28'h0, wr_be}, 32'h0);

        foreach (VECS[k]) begin
            drive(VECS[k].st, VECS[k].f3, VECS[k].imm[11:5], VECS[k].imm[4:0], VECS[k].imm[4:0],
                  VECS[k].base, VECS[k].src, VECS[k].rw);
            check($sformatf("R2 vec %0d mem_addr", k), mem_addr, VECS[k].e_addr);
            check($sformatf("R%0d vec %0d ld_result", VECS[k].req, k), ld_result, VECS[k].e_res);
            check($sformatf("R%0d vec %0d wr_be", VECS[k].req, k), {28'h0, wr_be}, {28'h0, VECS[k].e_be});
            if (VECS[k].e_be != 4'h0)
                check($sformatf("R%0d vec %0d wr_data", VECS[k].req, k), wr_data, VECS[k].e_data);
        end

        // R1: load takes low offset bits from imm_lo_i, not imm_lo_s
        drive(1'b0, 3'd2, 7'h00, 5'd4, 5'h1F, 32'h8000_0000, SV, RW);
        check("R1 load offset field", mem_addr, 32'h0000_0004);
        // R1: store takes low offset bits from imm_lo_s, not imm_lo_i
        drive(1'b1, 3'd2, 7'h00, 5'h1F, 5'd8, 32'h8000_0000, SV, RW);
        check("R1 store offset field", mem_addr, 32'h0000_0008);
        check("R10 store data", wr_data, SV);
        // R1: sign of upper field applies to store offset (-32 + 8 = -24)
        drive(1'b1, 3'd0, 7'h7F, 5'h00, 5'd8, 32'h8000_0100, SV, RW);
        check("R1 negative store offset addr", mem_addr, 32'h0000_00E8);
        check("R8 lane from negative offset", {28'h0, wr_be}, 32'h1);
        // R6: unsigned byte at lane 1
        drive(1'b0, 3'd4, 7'h00, 5'd1, 5'd0, 32'h8000_0100, SV, RW);
        check("R6 unsigned byte lane 1", ld_result, 32'h0000_00C6);
        // R11: store code 3 writes nothing
        drive(1'b1, 3'd3, 7'h00, 5'd0, 5'd0, 32'h8000_0100, SV, RW);
        check("R11 store code 3", {28'h0, wr_be}, 32'h0);
        // R7: store access returns zero load value
        check("R7 store ld_result", ld_result, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule